// File: doc/BRIEF.md
# Sprite Attribute List Walker

The walker follows a linked chain of 8-byte sprite descriptors held in a byte-wide video memory. A start request latches a table register, and the walker begins at descriptor 0 of that table. For each descriptor it reads all eight bytes through a synchronous read port and decodes the position, palette, priority, pattern and link fields. It then offers the decoded descriptor to a consumer through a valid/ready handshake.

Once the consumer accepts a descriptor, the walker jumps to the descriptor named by its link field. The walk ends after a descriptor whose link is zero, or after a fixed number of descriptors have been delivered, whichever comes first. A one-cycle done pulse marks the end of the walk. The walker is meant to sit between the video memory arbiter and a per-line sprite selector. Drawing pixels and choosing sprites for a line are left to those other blocks.

Top module: `sprite_list_walker`

## Requirements
- R1: The table byte base is `start_tbl_i[6:0]` shifted left by 9, and bit 7 of the table input is ignored. Descriptor n starts at base + 8*n, and each walk begins at descriptor 0.
- R2: A descriptor is fetched as eight reads at byte offsets 0,1,...,7 in ascending order, one per cycle, each returning data on `mem_rdata_i` one cycle after `mem_rd_en_o`.
- R3: Y is 9 bits: bit 0 of byte 0 as the MSB, then byte 1. X is 9 bits: bit 0 of byte 6, then byte 7. All other bits of bytes 0 and 6, and all of byte 2, have no effect on any output.
- R4: The link is byte 3 bits [6:0], the priority is byte 4 bit 7, and the palette is byte 4 bits [6:5].
- R5: The pattern address is the 11-bit index {byte4[2:0], byte5} shifted left by 5, giving 16 bits. Byte 4 bits [4:3] have no effect on any output.
- R6: After a descriptor is accepted, the next descriptor fetched is the one whose number equals its link. The walk ends after a descriptor whose link is 0. `sd_index_o` reports the descriptor number.
- R7: No more than MAX_ENTRIES (default 80) descriptors are delivered per walk, even when the chain continues.
- R8: While `sd_valid_o` is high and `sd_ready_i` is low, all descriptor outputs stay stable and no memory read is issued.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last descriptor is accepted. In that cycle `busy_o` and `sd_valid_o` are already low.
- R10: A start request while `busy_o` is high is ignored: the running walk continues on its own table and chain.
- R11: `sd_valid_o` rises 9 clock edges after the edge that samples an accepted start request or a non-final acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only when idle |
| start_tbl_i | input | 8 | Table register; bits [6:0] select the base |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rdata_i | input | 8 | Read data, one cycle after the strobe |
| sd_valid_o | output | 1 | Decoded descriptor available |
| sd_ready_i | input | 1 | Consumer accepts the descriptor |
| sd_index_o | output | 7 | Descriptor number |
| sd_y_o | output | 9 | Y position |
| sd_x_o | output | 9 | X position |
| sd_link_o | output | 7 | Link to the next descriptor |
| sd_prio_o | output | 1 | Priority bit |
| sd_pal_o | output | 2 | Palette select |
| sd_pat_addr_o | output | 16 | Pattern byte address |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |

## Verification
Each read data byte is due on the edge after its strobe. Each descriptor becomes valid nine edges after the edge that sampled start or acceptance, and done is due on the edge after the final acceptance. The bench drives inputs and samples outputs on falling edges and counts those edges to check each of these latencies exactly. For the read sequence, it samples the strobe and address on each of the eight falling edges after start, and confirms the strobe is low on the ninth.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int SWK_DESC_BYTES = 8;
  localparam int SWK_OFF_W      = 3;

  typedef enum logic [1:0] {
    SWK_IDLE  = 2'd0,
    SWK_FETCH = 2'd1,
    SWK_DRAIN = 2'd2,
    SWK_HOLD  = 2'd3
  } swk_state_t;

  typedef struct packed {
    logic [8:0]  y;
    logic [8:0]  x;
    logic [6:0]  link;
    logic        prio;
    logic [1:0]  pal;
    logic [15:0] pat_addr;
  } swk_desc_t;
endpackage

// File: rtl/swk_addr_gen.sv
module swk_addr_gen #(
  parameter int ADDR_W     = 16,
  parameter int TBL_W      = 7,
  parameter int IDX_W      = 7,
  parameter int OFF_W      = 3,
  parameter int BASE_SHIFT = 9
) (
  input  logic [TBL_W-1:0]  tbl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int BASE_W = TBL_W + BASE_SHIFT;
  localparam int SLOT_W = IDX_W + OFF_W;

  logic [BASE_W-1:0] base_w;
  logic [SLOT_W-1:0] slot_w;

  always_comb begin
    base_w = {tbl, {BASE_SHIFT{1'b0}}};
    slot_w = {idx, off};
    addr   = ADDR_W'(base_w) + ADDR_W'(slot_w);
  end
endmodule

// File: rtl/swk_byte_buf.sv
module swk_byte_buf #(
  parameter int NBYTES = 8,
  parameter int OFF_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_en,
  input  logic [OFF_W-1:0]      cap_off,
  input  logic [7:0]            cap_data,
  output logic [NBYTES*8-1:0]   view
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [7:0] held;
    logic       hit;
    assign hit = cap_en && (cap_off == OFF_W'(k));
    always_ff @(posedge clk) begin
      if (rst) begin
        held <= '0;
      end else if (hit) begin
        held <= cap_data;
      end
    end
    assign view[k*8 +: 8] = hit ? cap_data : held;
  end
endmodule

// File: rtl/swk_decode.sv
module swk_decode
  import swk_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES*8-1:0] bytes_in,
  output swk_desc_t           desc
);
  logic [7:0] b0, b1, b3, b4, b5, b6, b7;

  always_comb begin
    b0 = bytes_in[0*8 +: 8];
    b1 = bytes_in[1*8 +: 8];
    b3 = bytes_in[3*8 +: 8];
    b4 = bytes_in[4*8 +: 8];
    b5 = bytes_in[5*8 +: 8];
    b6 = bytes_in[6*8 +: 8];
    b7 = bytes_in[7*8 +: 8];
    desc.y        = {b0[0], b1};
    desc.x        = {b6[0], b7};
    desc.link     = b3[6:0];
    desc.prio     = b4[7];
    desc.pal      = b4[6:5];
    desc.pat_addr = {b4[2:0], b5, 5'b00000};
  end
endmodule

// File: rtl/sprite_list_walker.sv
module sprite_list_walker
  import swk_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int TBL_W       = 7,
  parameter int IDX_W       = 7,
  parameter int BASE_SHIFT  = 9,
  parameter int MAX_ENTRIES = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [7:0]        start_tbl_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              sd_valid_o,
  input  logic              sd_ready_i,
  output logic [IDX_W-1:0]  sd_index_o,
  output logic [8:0]        sd_y_o,
  output logic [8:0]        sd_x_o,
  output logic [6:0]        sd_link_o,
  output logic              sd_prio_o,
  output logic [1:0]        sd_pal_o,
  output logic [15:0]       sd_pat_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W    = $clog2(MAX_ENTRIES + 1);
  localparam int LAST_OFF = SWK_DESC_BYTES - 1;

  swk_state_t           state_q;
  logic [TBL_W-1:0]     tbl_q;
  logic [IDX_W-1:0]     idx_q;
  logic [SWK_OFF_W-1:0] iss_off_q;
  logic [SWK_OFF_W-1:0] cap_off_q;
  logic                 rd_pend_q;
  logic [CNT_W-1:0]     vis_q;
  logic                 done_q;
  swk_desc_t            out_q;
  logic [IDX_W-1:0]     out_idx_q;

  logic [SWK_DESC_BYTES*8-1:0] byte_view;
  swk_desc_t                   dec;
  logic                        accept;
  logic [CNT_W-1:0]            vis_next;
  logic                        walk_end;

  swk_addr_gen #(
    .ADDR_W(ADDR_W), .TBL_W(TBL_W), .IDX_W(IDX_W),
    .OFF_W(SWK_OFF_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_addr (
    .tbl(tbl_q), .idx(idx_q), .off(iss_off_q), .addr(mem_addr_o)
  );

  swk_byte_buf #(.NBYTES(SWK_DESC_BYTES), .OFF_W(SWK_OFF_W)) u_buf (
    .clk(clk), .rst(rst), .cap_en(rd_pend_q), .cap_off(cap_off_q),
    .cap_data(mem_rdata_i), .view(byte_view)
  );

  swk_decode #(.NBYTES(SWK_DESC_BYTES)) u_dec (
    .bytes_in(byte_view), .desc(dec)
  );

  assign mem_rd_en_o = (state_q == SWK_FETCH);
  assign sd_valid_o  = (state_q == SWK_HOLD);
  assign busy_o      = (state_q != SWK_IDLE);
  assign done_o      = done_q;
  assign accept      = sd_valid_o && sd_ready_i;
  assign vis_next    = vis_q + CNT_W'(1);
  assign walk_end    = (out_q.link == 7'd0) || (vis_next == CNT_W'(MAX_ENTRIES));

  assign sd_index_o    = out_idx_q;
  assign sd_y_o        = out_q.y;
  assign sd_x_o        = out_q.x;
  assign sd_link_o     = out_q.link;
  assign sd_prio_o     = out_q.prio;
  assign sd_pal_o      = out_q.pal;
  assign sd_pat_addr_o = out_q.pat_addr;

  // read tracking: data arrives the cycle after the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      cap_off_q <= '0;
    end else begin
      rd_pend_q <= mem_rd_en_o;
      cap_off_q <= iss_off_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SWK_IDLE;
      tbl_q     <= '0;
      idx_q     <= '0;
      iss_off_q <= '0;
      vis_q     <= '0;
      done_q    <= 1'b0;
      out_q     <= '0;
      out_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SWK_IDLE: begin
          if (start_i) begin
            tbl_q     <= start_tbl_i[TBL_W-1:0];
            idx_q     <= '0;
            iss_off_q <= '0;
            vis_q     <= '0;
            state_q   <= SWK_FETCH;
          end
        end
        SWK_FETCH: begin
          iss_off_q <= iss_off_q + SWK_OFF_W'(1);
          if (iss_off_q == SWK_OFF_W'(LAST_OFF)) begin
            state_q <= SWK_DRAIN;
          end
        end
        SWK_DRAIN: begin
          out_q     <= dec;
          out_idx_q <= idx_q;
          state_q   <= SWK_HOLD;
        end
        SWK_HOLD: begin
          if (accept) begin
            vis_q <= vis_next;
            if (walk_end) begin
              state_q <= SWK_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q     <= out_q.link;
              iss_off_q <= '0;
              state_q   <= SWK_FETCH;
            end
          end
        end
        default: state_q <= SWK_IDLE;
      endcase
    end
  end

  // R8: outputs hold while the consumer stalls
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (sd_valid_o && !sd_ready_i) |=> (sd_valid_o && $stable(out_q) && $stable(out_idx_q)));

  // R8: no memory traffic during hold
  a_r8_no_read_in_hold: assert property (@(posedge clk) disable iff (rst)
    sd_valid_o |-> !mem_rd_en_o);

  // R2: consecutive reads step by one byte
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en_o && $past(mem_rd_en_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  // R9: done is a single-cycle pulse with the walker idle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !sd_valid_o));

  // R7: visit count never passes the cap
  a_r7_visit_cap: assert property (@(posedge clk) disable iff (rst)
    vis_q <= CNT_W'(MAX_ENTRIES));

  // R10: the latched table survives a start while busy
  a_r10_table_kept: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (tbl_q == $past(tbl_q)));
endmodule

// File: tb/sim_sprite_list_walker.sv
`timescale 1ns/1ps
module sim_sprite_list_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  start_tbl_i = '0;
  logic        mem_rd_en_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        sd_valid_o;
  logic        sd_ready_i = 1'b0;
  logic [6:0]  sd_index_o;
  logic [8:0]  sd_y_o, sd_x_o;
  logic [6:0]  sd_link_o;
  logic        sd_prio_o;
  logic [1:0]  sd_pal_o;
  logic [15:0] sd_pat_addr_o;
  logic        busy_o, done_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] mem [0:4095];

  always #2.5 clk = ~clk;

  always @(posedge clk) if (mem_rd_en_o) mem_rdata_i <= mem[mem_addr_o[11:0]];

  sprite_list_walker u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_desc(input int base, input int n, input logic [8:0] y, input logic [8:0] x,
                          input logic [6:0] link, input logic prio, input logic [1:0] pal,
                          input logic [10:0] pat, input logic [7:0] junk);
    int a = base + 8 * n;
    mem[a+0] = {junk[7:1], y[8]};
    mem[a+1] = y[7:0];
    mem[a+2] = junk;
    mem[a+3] = {junk[0], link};
    mem[a+4] = {prio, pal, junk[1:0], pat[10:8]};
    mem[a+5] = pat[7:0];
    mem[a+6] = {junk[7:1], x[8]};
    mem[a+7] = x[7:0];
  endtask

  task automatic start_walk(input logic [7:0] tbl);
    @(negedge clk);
    start_i = 1'b1;
    start_tbl_i = tbl;
    @(posedge clk);
    #1 start_i = 1'b0;
  endtask

  // wait for a descriptor, check it, accept it
  task automatic take(input string req, input bit chk_lat, input logic [6:0] idx,
                      input logic [8:0] y, input logic [8:0] x, input logic [6:0] link,
                      input logic prio, input logic [1:0] pal, input logic [10:0] pat, input bit last);
    int cyc = 0;
    forever begin
      @(negedge clk);
      if (sd_valid_o || cyc > 2000) break;
      cyc++;
    end
    if (chk_lat) chk("R11", "valid latency", cyc, 9);
    chk("R6", "index", sd_index_o, idx);
    chk(req, "y", sd_y_o, y);
    chk(req, "x", sd_x_o, x);
    chk("R4", "link", sd_link_o, link);
    chk("R4", "prio", sd_prio_o, prio);
    chk("R4", "pal", sd_pal_o, pal);
    chk("R5", "pattern addr", sd_pat_addr_o, {pat, 5'b0});
    sd_ready_i = 1'b1;
    @(posedge clk);
    #1 sd_ready_i = 1'b0;
    if (last) begin
      @(negedge clk);
      chk("R9", "done pulse", done_o, 1);
      chk("R9", "busy low at done", busy_o, 0);
      chk("R9", "valid low at done", sd_valid_o, 0);
      @(negedge clk);
      chk("R9", "done drops", done_o, 0);
    end
  endtask

  task automatic t_reset;
    chk("R9", "reset busy", busy_o, 0);
    chk("R8", "reset valid", sd_valid_o, 0);
    chk("R2", "reset read", mem_rd_en_o, 0);
    chk("R9", "reset done", done_o, 0);
  endtask

  // R1 R2 R6: chain 0 -> 3 -> 5 -> end in table 0x04 (base 0x800)
  task automatic t_chain;
    set_desc(12'h800, 0, 9'h1A5, 9'h0F0, 7'd3, 1'b1, 2'd2, 11'h5A3, 8'h00);
    set_desc(12'h800, 3, 9'h080, 9'h17F, 7'd5, 1'b0, 2'd1, 11'h001, 8'h00);
    set_desc(12'h800, 5, 9'h000, 9'h1FF, 7'd0, 1'b1, 2'd3, 11'h7FF, 8'h00);
    start_walk(8'h04);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2", "read strobe", mem_rd_en_o, 1);
      chk("R1", "read address", mem_addr_o, 16'h0800 + k);
    end
    @(negedge clk);
    chk("R2", "strobe off after 8", mem_rd_en_o, 0);
    take("R3", 0, 7'd0, 9'h1A5, 9'h0F0, 7'd3, 1'b1, 2'd2, 11'h5A3, 0);
    take("R3", 1, 7'd3, 9'h080, 9'h17F, 7'd5, 1'b0, 2'd1, 11'h001, 0);
    take("R6", 1, 7'd5, 9'h000, 9'h1FF, 7'd0, 1'b1, 2'd3, 11'h7FF, 1);
  endtask

  // R3 R5 R1: junk bits set everywhere ignored; table bit 7 ignored (0x85 -> base 0xA00)
  task automatic t_mask;
    set_desc(12'hA00, 0, 9'h0C3, 9'h101, 7'd1, 1'b0, 2'd0, 11'h123, 8'hFF);
    set_desc(12'hA00, 1, 9'h100, 9'h002, 7'd0, 1'b0, 2'd2, 11'h400, 8'hFE);
    start_walk(8'h85);
    take("R3", 1, 7'd0, 9'h0C3, 9'h101, 7'd1, 1'b0, 2'd0, 11'h123, 0);
    take("R3", 1, 7'd1, 9'h100, 9'h002, 7'd0, 1'b0, 2'd2, 11'h400, 1);
  endtask

  // R7: chain never terminates within 80; table 0x02 (base 0x400)
  task automatic t_limit;
    for (int n = 0; n < 90; n++)
      set_desc(12'h400, n, 9'(n * 3), 9'(n), 7'(n + 1), 1'b0, 2'd1, 11'(n), 8'h00);
    start_walk(8'h02);
    for (int n = 0; n < 80; n++)
      take("R7", 1, 7'(n), 9'(n * 3), 9'(n), 7'(n + 1), 1'b0, 2'd1, 11'(n), n == 79);
    repeat (12) @(negedge clk);
    chk("R7", "no 81st descriptor", sd_valid_o, 0);
  endtask

  // R8: stall the consumer
  task automatic t_backpressure;
    logic [8:0] y0;
    start_walk(8'h04);
    while (!sd_valid_o) @(negedge clk);
    y0 = sd_y_o;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R8", "valid held", sd_valid_o, 1);
      chk("R8", "y stable", sd_y_o, y0);
      chk("R8", "no read in hold", mem_rd_en_o, 0);
    end
    take("R8", 0, 7'd0, 9'h1A5, 9'h0F0, 7'd3, 1'b1, 2'd2, 11'h5A3, 0);
    take("R8", 1, 7'd3, 9'h080, 9'h17F, 7'd5, 1'b0, 2'd1, 11'h001, 0);
    take("R8", 1, 7'd5, 9'h000, 9'h1FF, 7'd0, 1'b1, 2'd3, 11'h7FF, 1);
  endtask

  // R10: starts mid-walk with another table (0x07 -> 0xE00) have no effect
  task automatic t_start_ignored;
    set_desc(12'hC00, 0, 9'h011, 9'h022, 7'd2, 1'b0, 2'd0, 11'h010, 8'h00);
    set_desc(12'hC00, 2, 9'h033, 9'h044, 7'd0, 1'b1, 2'd1, 11'h020, 8'h00);
    set_desc(12'hE00, 0, 9'h1EE, 9'h1DD, 7'd0, 1'b0, 2'd3, 11'h030, 8'h00);
    start_walk(8'h06);
    start_walk(8'h07);
    take("R10", 0, 7'd0, 9'h011, 9'h022, 7'd2, 1'b0, 2'd0, 11'h010, 0);
    start_walk(8'h07);
    take("R10", 0, 7'd2, 9'h033, 9'h044, 7'd1 - 7'd1, 1'b1, 2'd1, 11'h020, 1);
    repeat (12) @(negedge clk);
    chk("R10", "no walk started", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_chain();
    t_mask();
    t_limit();
    t_backpressure();
    t_start_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule